// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block steers operands and controls stalls for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It receives the fields of the instruction now in decode: up to three source register numbers, each with a use flag, and a destination number with write-enable and load flags. It keeps a small shadow of the destination fields that have moved on into the execute and memory stages. From that shadow it decides where each source operand of the decoding instruction will come from when that instruction reaches execute. There are three choices: the register file, the ALU result in the execute/memory pipeline register, or the output of the memory stage.

The choices are registered, so they line up with the instruction while it executes. One case forwarding cannot cover is a load whose value is needed by the very next instruction. There the block freezes fetch and decode for one cycle and sends an empty slot into execute. One cycle later the loaded value sits at the memory-stage output and is bypassed from there.

Top module: `opnd_bypass_ctrl`

## Requirements
- R1: While reset is held and after it is released, `fwd_sel_o` reads all zero and `hold_o` and `ex_bubble_o` read 0.
- R2: An operand whose register is written by the instruction one ahead (write-enable high) gets select code 1, the execute/memory ALU result, on `fwd_sel_o` in the cycle after it leaves decode.
- R3: An operand whose register is written by the instruction two ahead, with no closer writer, gets select code 2, the memory-stage output.
- R4: Each of the operands, held in slots [i] of `fwd_sel_o` (bits 2i+1:2i), is resolved on its own, so one instruction can mix codes 0, 1 and 2.
- R5: A producer whose write-enable is low never matches. Register number 0 matches like any other number.
- R6: When both earlier instructions write the same source register, the nearer one wins (code 1).
- R7: A load followed at once by an instruction that uses the loaded register raises `hold_o` for exactly one cycle. The next cycle shows `ex_bubble_o` = 1 with every select at code 0, and decode is presented again.
- R8: After that stall, the re-presented consumer gets code 2 for the loaded register.
- R9: A load separated from its consumer by one unrelated instruction causes no hold. The consumer gets code 2.
- R10: A source whose use flag is low never matches and never causes a hold, even if its number equals a pending load destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src_i | input | NSRC x REG_W | Source register numbers of the decoding instruction |
| dec_src_use_i | input | NSRC | Per-source use flag |
| dec_dst_i | input | REG_W | Destination register of the decoding instruction |
| dec_we_i | input | 1 | Decoding instruction writes its destination |
| dec_ld_i | input | 1 | Decoding instruction is a load |
| hold_o | output | 1 | Freeze fetch and decode this cycle; the execute slot gets an empty instruction |
| ex_bubble_o | output | 1 | The instruction now in execute is an inserted empty slot |
| fwd_sel_o | output | NSRC x 2 | Per-operand source for execute: 0 register file, 1 execute/memory ALU result, 2 memory-stage output |

## Verification
The bench targets distance-one and distance-two producers of the same register. A design with the priority reversed would hand the consumer a stale value from two instructions back. It also drives producers with write-enable low and writes to register 0. A design that ignores write-enable would forward from instructions that write nothing, and one that special-cases register 0 would miss a real dependence. Load-use pairs are checked both back to back and separated by one instruction. A wrong design there would skip the stall, stall twice, stall when nothing waits, or read the register file after the stall instead of the memory-stage output. Unused sources that alias a load destination are exercised to catch needless stalls.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    BYP_REGFILE = 2'd0,
    BYP_EXMEM   = 2'd1,
    BYP_MEMOUT  = 2'd2
  } byp_sel_e;

  // Nearer producer first, then the older one, else the register file.
  function automatic byp_sel_e pick_bypass(input logic hit_near, input logic hit_far);
    if (hit_near)     return BYP_EXMEM;
    else if (hit_far) return BYP_MEMOUT;
    else              return BYP_REGFILE;
  endfunction

  // A load in the stage just ahead that feeds this operand cannot be bypassed in time.
  function automatic logic load_too_early(input logic hit_near, input logic near_is_load);
    return hit_near && near_is_load;
  endfunction

endpackage

// File: rtl/byp_stage_track.sv
module byp_stage_track #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert_bubble,
  input  logic [REG_W-1:0] dec_dst,
  input  logic             dec_we,
  input  logic             dec_ld,
  output logic [REG_W-1:0] ex_dst,
  output logic             ex_we,
  output logic             ex_ld,
  output logic [REG_W-1:0] mem_dst,
  output logic             mem_we
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_dst  <= '0;
      ex_we   <= 1'b0;
      ex_ld   <= 1'b0;
      mem_dst <= '0;
      mem_we  <= 1'b0;
    end else begin
      mem_dst <= ex_dst;
      mem_we  <= ex_we;
      if (insert_bubble) begin
        ex_dst <= '0;
        ex_we  <= 1'b0;
        ex_ld  <= 1'b0;
      end else begin
        ex_dst <= dec_dst;
        ex_we  <= dec_we;
        ex_ld  <= dec_ld && dec_we;
      end
    end
  end

endmodule

// File: rtl/byp_src_match.sv
module byp_src_match
  import bypass_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_use,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_we,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_we,
  output logic             hit_near,
  output logic             hit_far,
  output logic             ld_hazard,
  output logic [1:0]       sel
);

  always_comb begin
    hit_near  = src_use && ex_we  && (ex_dst  == src);
    hit_far   = src_use && mem_we && (mem_dst == src);
    ld_hazard = load_too_early(hit_near, ex_ld);
    sel       = pick_bypass(hit_near, hit_far);
  end

endmodule

// File: rtl/byp_interlock.sv
module byp_interlock #(
  parameter int unsigned NSRC = 3
) (
  input  logic [NSRC-1:0] ld_hazard,
  output logic            hold
);

  assign hold = |ld_hazard;

endmodule

// File: rtl/byp_sel_reg.sv
module byp_sel_reg #(
  parameter int unsigned NSRC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [NSRC-1:0][1:0] sel_next,
  output logic [NSRC-1:0][1:0] sel_q,
  output logic                 bubble_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      bubble_q <= 1'b0;
    end else if (hold) begin
      sel_q    <= '0;
      bubble_q <= 1'b1;
    end else begin
      sel_q    <= sel_next;
      bubble_q <= 1'b0;
    end
  end

endmodule

// File: rtl/opnd_bypass_ctrl.sv
module opnd_bypass_ctrl #(
  parameter int unsigned NSRC  = 3,
  parameter int unsigned REG_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0][REG_W-1:0] dec_src_i,
  input  logic [NSRC-1:0]           dec_src_use_i,
  input  logic [REG_W-1:0]          dec_dst_i,
  input  logic                      dec_we_i,
  input  logic                      dec_ld_i,
  output logic                      hold_o,
  output logic                      ex_bubble_o,
  output logic [NSRC-1:0][1:0]      fwd_sel_o
);

  logic [REG_W-1:0]     ex_dst, mem_dst;
  logic                 ex_we, ex_ld, mem_we;
  logic [NSRC-1:0]      hit_near, hit_far, ld_hazard;
  logic [NSRC-1:0][1:0] sel_next;
  logic                 ex_is_load;
  logic [NSRC-1:0]      slot_memout;
  logic                 sel_memout_any;

  byp_stage_track #(.REG_W(REG_W)) u_track (
    .clk(clk), .rst_n(rst_n), .insert_bubble(hold_o),
    .dec_dst(dec_dst_i), .dec_we(dec_we_i), .dec_ld(dec_ld_i),
    .ex_dst(ex_dst), .ex_we(ex_we), .ex_ld(ex_ld),
    .mem_dst(mem_dst), .mem_we(mem_we)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    byp_src_match #(.REG_W(REG_W)) u_match (
      .src(dec_src_i[i]), .src_use(dec_src_use_i[i]),
      .ex_dst(ex_dst), .ex_we(ex_we), .ex_ld(ex_ld),
      .mem_dst(mem_dst), .mem_we(mem_we),
      .hit_near(hit_near[i]), .hit_far(hit_far[i]),
      .ld_hazard(ld_hazard[i]), .sel(sel_next[i])
    );
    assign slot_memout[i] = (fwd_sel_o[i] == 2'd2);
  end

  byp_interlock #(.NSRC(NSRC)) u_lock (
    .ld_hazard(ld_hazard), .hold(hold_o)
  );

  byp_sel_reg #(.NSRC(NSRC)) u_selq (
    .clk(clk), .rst_n(rst_n), .hold(hold_o), .sel_next(sel_next),
    .sel_q(fwd_sel_o), .bubble_q(ex_bubble_o)
  );

  // Named events for the checker
  assign ex_is_load     = ex_we && ex_ld;
  assign sel_memout_any = |slot_memout;

endmodule

// File: rtl/byp_checker.sv
module byp_checker #(
  parameter int unsigned NSRC = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hold,
  input logic                 ex_bubble,
  input logic [NSRC-1:0][1:0] fwd_sel,
  input logic                 ex_is_load,
  input logic                 sel_memout_any
);

  assert_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  assert_bubble_follows_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ex_bubble);

  assert_bubble_uses_regfile_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (fwd_sel == '0));

  assert_stall_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ex_is_load);

  assert_memout_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ##1 sel_memout_any);

endmodule

bind opnd_bypass_ctrl byp_checker #(.NSRC(NSRC)) u_byp_checker (
  .clk(clk), .rst_n(rst_n), .hold(hold_o), .ex_bubble(ex_bubble_o),
  .fwd_sel(fwd_sel_o), .ex_is_load(ex_is_load), .sel_memout_any(sel_memout_any)
);

// File: tb/opnd_bypass_ctrl_bench.sv
`timescale 1ns/1ps
module opnd_bypass_ctrl_bench;
  localparam int NSRC = 3;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NSRC-1:0][RW-1:0] src;
  logic [NSRC-1:0]         use_f;
  logic [RW-1:0]           dst;
  logic                    we, ld;
  logic                    hold;
  logic                    bub;
  logic [NSRC-1:0][1:0]    sel;

  opnd_bypass_ctrl #(.NSRC(NSRC), .REG_W(RW)) u_opnd_bypass_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_src_i(src), .dec_src_use_i(use_f),
    .dec_dst_i(dst), .dec_we_i(we), .dec_ld_i(ld),
    .hold_o(hold), .ex_bubble_o(bub), .fwd_sel_o(sel)
  );

  // Bench view of the two producers ahead of decode
  logic [RW-1:0]        m_ex_dst, m_mem_dst;
  logic                 m_ex_we, m_ex_ld, m_mem_we;
  logic [NSRC-1:0][1:0] exp_sel;
  logic                 exp_bub, last_hold;
  int checks = 0;
  int fails  = 0;

  function automatic logic [1:0] want_sel(input logic [RW-1:0] s, input logic u);
    if (!u) return 2'd0;
    if (m_ex_we && m_ex_dst == s) return 2'd1;
    if (m_mem_we && m_mem_dst == s) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic want_hold();
    logic h = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (use_f[k] && m_ex_we && m_ex_ld && m_ex_dst == src[k]) h = 1'b1;
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: present one decode slot, follow it through one clock.
  task automatic issue(input logic [RW-1:0] a, input logic [RW-1:0] b, input logic [RW-1:0] c,
                       input logic [NSRC-1:0] u, input logic [RW-1:0] d,
                       input logic w, input logic l);
    logic [NSRC-1:0][1:0] nxt;
    logic h;
    src[0] = a; src[1] = b; src[2] = c; use_f = u; dst = d; we = w; ld = l;
    #1;
    h = want_hold();
    last_hold = hold;
    chk("R7/R10 hold", {31'd0, hold}, {31'd0, h});
    for (int k = 0; k < NSRC; k++) nxt[k] = want_sel(src[k], use_f[k]);
    @(posedge clk);
    m_mem_dst = m_ex_dst; m_mem_we = m_ex_we;
    if (h) begin
      m_ex_we = 1'b0; m_ex_ld = 1'b0; exp_sel = '0; exp_bub = 1'b1;
    end else begin
      m_ex_dst = d; m_ex_we = w; m_ex_ld = l && w; exp_sel = nxt; exp_bub = 1'b0;
    end
    @(negedge clk);
    chk("R2/R3/R4/R6 model selects", {26'd0, sel}, {26'd0, exp_sel});
    chk("R7 bubble flag", {31'd0, bub}, {31'd0, exp_bub});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    src = '0; use_f = '0; dst = '0; we = 1'b0; ld = 1'b0;
    m_ex_dst = '0; m_mem_dst = '0; m_ex_we = 0; m_ex_ld = 0; m_mem_we = 0;
    exp_sel = '0; exp_bub = 0; last_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset selects", {26'd0, sel}, 32'd0);
    chk("R1 reset hold", {31'd0, hold}, 32'd0);
    chk("R1 reset bubble", {31'd0, bub}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {24'd0, sel, hold, bub}, 32'd0);

    // R2: distance one
    issue(0, 0, 0, 3'b000, 3'd1, 1, 0);
    issue(3'd1, 0, 0, 3'b001, 3'd2, 1, 0);
    chk("R2 near producer", {30'd0, sel[0]}, 32'd1);
    // R3: distance two
    issue(0, 0, 0, 3'b000, 3'd3, 1, 0);
    issue(0, 0, 0, 3'b000, 3'd0, 0, 0);
    issue(0, 3'd3, 0, 3'b010, 3'd4, 0, 0);
    chk("R3 older producer", {30'd0, sel[1]}, 32'd2);
    // R4: mixed operands
    issue(0, 0, 0, 3'b000, 3'd4, 1, 0);
    issue(0, 0, 0, 3'b000, 3'd5, 1, 0);
    issue(3'd5, 3'd4, 3'd6, 3'b111, 3'd7, 0, 0);
    chk("R4 mixed operands", {26'd0, sel}, {26'd0, 2'd0, 2'd2, 2'd1});
    // R5: write-enable low, register 0
    issue(0, 0, 0, 3'b000, 3'd6, 0, 0);
    issue(3'd6, 0, 0, 3'b001, 3'd1, 0, 0);
    chk("R5 disabled write", {30'd0, sel[0]}, 32'd0);
    issue(0, 0, 0, 3'b000, 3'd0, 1, 0);
    issue(3'd0, 0, 0, 3'b001, 3'd1, 0, 0);
    chk("R5 register zero", {30'd0, sel[0]}, 32'd1);
    // R6: priority
    issue(0, 0, 0, 3'b000, 3'd2, 1, 0);
    issue(0, 0, 0, 3'b000, 3'd2, 1, 0);
    issue(0, 0, 3'd2, 3'b100, 3'd1, 0, 0);
    chk("R6 nearer wins", {30'd0, sel[2]}, 32'd1);
    // R10: unused source aliasing a load
    issue(0, 0, 0, 3'b000, 3'd7, 1, 1);
    issue(3'd7, 3'd7, 3'd7, 3'b000, 3'd1, 0, 0);
    chk("R10 unused no hold", {31'd0, last_hold}, 32'd0);
    chk("R10 unused select", {26'd0, sel}, 32'd0);
    // R7/R8: load-use
    issue(0, 0, 0, 3'b000, 3'd1, 1, 1);
    issue(0, 3'd1, 0, 3'b010, 3'd3, 1, 0);
    chk("R7 hold raised", {31'd0, last_hold}, 32'd1);
    chk("R7 bubble in execute", {31'd0, bub}, 32'd1);
    chk("R7 bubble selects", {26'd0, sel}, 32'd0);
    issue(0, 3'd1, 0, 3'b010, 3'd3, 1, 0);
    chk("R7 single stall", {31'd0, last_hold}, 32'd0);
    chk("R8 memory-stage select", {30'd0, sel[1]}, 32'd2);
    // R9: load, gap, consumer
    issue(0, 0, 0, 3'b000, 3'd2, 1, 1);
    issue(0, 0, 0, 3'b000, 3'd5, 1, 0);
    issue(3'd2, 0, 0, 3'b001, 3'd6, 1, 0);
    chk("R9 no hold", {31'd0, last_hold}, 32'd0);
    chk("R9 memory-stage select", {30'd0, sel[0]}, 32'd2);

    // Random traffic; a held slot is presented again unchanged
    for (int n = 0; n < 3000; n++) begin
      if (last_hold) begin
        issue(src[0], src[1], src[2], use_f, dst, we, ld);
      end else begin
        logic w = ($urandom % 4) != 0;
        logic l = w && (($urandom % 3) == 0);
        issue(RW'($urandom), RW'($urandom), RW'($urandom), NSRC'($urandom),
              RW'($urandom), w, l);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule